// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block looks through one group of eight page-table entries for a translation that matches a requested virtual page. Each entry is a pair of 64-bit words. The first word holds the page-number tag and the flag bits. The second word holds the real page number and the protection and usage bits. A search begins with a one-cycle `start` pulse that carries three things: the group index, the wanted first-word value, and a flag saying whether the entry must come from the primary or the secondary hash. The block then reads the slots of the group one per cycle, lowest slot first, through a synchronous read port. That port returns both words of a slot `RD_LAT` cycles after the request. The block compares each returned entry and reports the first slot that matches.

An entry matches when four conditions hold:
- Its first word agrees with the wanted value in bits 63:7. This field is the segment-size field in bits 63:62 plus the abbreviated page number in bits 61:7.
- Its valid bit (bit 0) is set.
- Its secondary-hash bit (bit 1) equals the requested flag.
- The other low flag bits play no part: bit 2 is large page, bit 3 is software lock, bit 4 is bolted, and bits 6:5 are unused.

On a hit, the block returns the slot index and that entry's second word without changes. In that word, the real page number is in bits 61:12, protection in bits 1:0, no-execute in bit 2, changed in bit 7 and referenced in bit 8. The block only reads memory and never writes it.

The control is a three-state machine:
- IDLE waits for `start`.
- SCAN issues one read per cycle.
- DRAIN waits for the reads still in flight after the last slot has been issued.

The transitions are:
- LAUNCH: IDLE to SCAN, on `start`.
- ALL_ISSUED: SCAN to DRAIN, after the last slot's read.
- FOUND: SCAN or DRAIN to IDLE, when a returned entry matches.
- EXHAUSTED: DRAIN to IDLE, when the last slot returns with no match.

On FOUND, reads still in flight are discarded.

Top module: `hpte_group_search`

## Requirements
- R1: While and after reset, with no search started, `done`, `hit`, `rd_en`, `hit_slot` and `hit_r` are all zero.
- R2: A search reads slots in ascending order, one per consecutive cycle, starting at slot 0. The address is {group index, slot} with the slot in the low 3 bits. No read is issued in the cycle `done` is high.
- R3: A difference between the wanted value and an entry's first word in bits 6:0 does not prevent a match. A difference in any of bits 63:7 does.
- R4: An entry whose bit 0 (valid) is clear never matches.
- R5: An entry matches only when its bit 1 equals `use_sec`.
- R6: When several slots match, the lowest-numbered one is reported.
- R7: A hit in slot k raises `done` with `hit`=1, `hit_slot`=k and `hit_r` equal to that slot's second word. This happens k+1+RD_LAT cycles after the clock edge that accepted `start`.
- R8: A miss raises `done` with `hit`=0, `hit_slot`=0 and `hit_r`=0. This happens 8+RD_LAT cycles after the accepting edge.
- R9: `done` is high for exactly one cycle per search.
- R10: `start` is ignored while a search is in progress: it does not change that search's result, and it does not add another `done`. A `start` given in the cycle `done` is high is accepted.
- R11: `hit`, `hit_slot` and `hit_r` hold their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Search request pulse, taken in IDLE only |
| grp_idx | input | GRP_W | Group index of the search |
| tgt_v | input | 64 | Wanted first-word value |
| use_sec | input | 1 | Required value of the secondary-hash bit |
| rd_en | output | 1 | Read request to entry memory |
| rd_addr | output | GRP_W+3 | Entry address {group, slot} |
| rd_v | input | 64 | First word of the entry read, RD_LAT cycles after the request |
| rd_r | input | 64 | Second word of the entry read |
| done | output | 1 | One-cycle end-of-search pulse |
| hit | output | 1 | A matching slot was found |
| hit_slot | output | 3 | Index of the matching slot |
| hit_r | output | 64 | Second word of the matching entry |

## Verification
For every search, the driver records the cycle in which `start` is accepted. It then sets the deadline for `done`: slot+1+RD_LAT cycles later for a hit, and 8+RD_LAT cycles later for a miss. The monitor compares the measured distance with that deadline, together with the hit flag, the slot and the returned word. Every read address is checked at the cycle it appears, for the right group and the next slot in order. The bench also flags any `done` that arrives with no search outstanding, and any `done` that lasts longer than one cycle. The outputs are checked again several cycles after a result to confirm they are held.

// File: rtl/hpte_pkg.sv
package hpte_pkg;
    localparam int ENTRY_DW  = 64;
    localparam int VALID_POS = 0;
    localparam int SEC_POS   = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } scan_state_e;
endpackage

// File: rtl/hpte_slot_match.sv
module hpte_slot_match #(
    parameter int DW        = 64,
    parameter int FLAG_BITS = 7
) (
    input  logic [DW-1:0] ent_v,
    input  logic [DW-1:0] want_v,
    input  logic          want_sec,
    output logic          match
);
    import hpte_pkg::*;

    localparam logic [DW-1:0] TAG_MASK = {{(DW-FLAG_BITS){1'b1}}, {FLAG_BITS{1'b0}}};

    logic tag_eq;
    logic is_valid;
    logic sec_eq;

    always_comb begin
        tag_eq   = ((ent_v ^ want_v) & TAG_MASK) == '0;
        is_valid = ent_v[VALID_POS];
        sec_eq   = ent_v[SEC_POS] == want_sec;
        match    = tag_eq && is_valid && sec_eq;
    end
endmodule

// File: rtl/hpte_read_seq.sv
module hpte_read_seq #(
    parameter int GRP_W  = 10,
    parameter int SLOTS  = 8,
    parameter int RD_LAT = 1,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ADDR_W = GRP_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [GRP_W-1:0]  grp_in,
    input  logic              issue_en,
    input  logic              flush,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              issue_last,
    output logic              ret_valid,
    output logic [SLOT_W-1:0] ret_slot,
    output logic              ret_last
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [GRP_W-1:0]  grp_q;
    logic [SLOT_W-1:0] issue_slot;
    logic              tag_vld  [RD_LAT];
    logic [SLOT_W-1:0] tag_slot [RD_LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q      <= '0;
            issue_slot <= '0;
        end else if (launch) begin
            grp_q      <= grp_in;
            issue_slot <= '0;
        end else if (issue_en) begin
            issue_slot <= issue_slot + SLOT_W'(1);
        end
    end

    always_comb begin
        rd_en      = issue_en;
        rd_addr    = {grp_q, issue_slot};
        issue_last = issue_en && (issue_slot == LAST_SLOT);
    end

    // Tag pipeline that follows the memory latency so each returned word keeps its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_vld[0]  <= 1'b0;
            tag_slot[0] <= '0;
        end else begin
            tag_vld[0]  <= issue_en && !flush;
            tag_slot[0] <= issue_slot;
        end
    end

    for (genvar s = 1; s < RD_LAT; s++) begin : g_tag_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_vld[s]  <= 1'b0;
                tag_slot[s] <= '0;
            end else begin
                tag_vld[s]  <= tag_vld[s-1] && !flush;
                tag_slot[s] <= tag_slot[s-1];
            end
        end
    end

    always_comb begin
        ret_valid = tag_vld[RD_LAT-1];
        ret_slot  = tag_slot[RD_LAT-1];
        ret_last  = ret_valid && (ret_slot == LAST_SLOT);
    end
endmodule

// File: rtl/hpte_group_search.sv
module hpte_group_search #(
    parameter int GRP_W     = 10,
    parameter int SLOTS     = 8,
    parameter int RD_LAT    = 1,
    parameter int DW        = 64,
    parameter int FLAG_BITS = 7,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ADDR_W = GRP_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [GRP_W-1:0]  grp_idx,
    input  logic [DW-1:0]     tgt_v,
    input  logic              use_sec,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DW-1:0]     rd_v,
    input  logic [DW-1:0]     rd_r,
    output logic              done,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic [DW-1:0]     hit_r
);
    import hpte_pkg::*;

    scan_state_e       state_q;
    scan_state_e       state_d;
    logic [DW-1:0]     want_q;
    logic              sec_q;
    logic              launch;
    logic              issue_en;
    logic              issue_last;
    logic              ret_valid;
    logic [SLOT_W-1:0] ret_slot;
    logic              ret_last;
    logic              slot_match;
    logic              found;
    logic              finish;

    always_comb begin
        launch   = (state_q == ST_IDLE) && start;
        issue_en = (state_q == ST_SCAN);
        found    = ret_valid && slot_match;
        finish   = found || ret_last;
    end

    hpte_read_seq #(
        .GRP_W  (GRP_W),
        .SLOTS  (SLOTS),
        .RD_LAT (RD_LAT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .grp_in     (grp_idx),
        .issue_en   (issue_en),
        .flush      (finish),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .issue_last (issue_last),
        .ret_valid  (ret_valid),
        .ret_slot   (ret_slot),
        .ret_last   (ret_last)
    );

    hpte_slot_match #(
        .DW        (DW),
        .FLAG_BITS (FLAG_BITS)
    ) u_match (
        .ent_v    (rd_v),
        .want_v   (want_q),
        .want_sec (sec_q),
        .match    (slot_match)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_q <= '0;
            sec_q  <= 1'b0;
        end else if (launch) begin
            want_q <= tgt_v;
            sec_q  <= use_sec;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SCAN;
            ST_SCAN: begin
                if (finish)          state_d = ST_IDLE;
                else if (issue_last) state_d = ST_DRAIN;
            end
            ST_DRAIN: if (finish) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            hit      <= 1'b0;
            hit_slot <= '0;
            hit_r    <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                hit      <= found;
                hit_slot <= found ? ret_slot : '0;
                hit_r    <= found ? rd_r : '0;
            end
        end
    end
endmodule

// File: rtl/hpte_group_search_chk.sv
module hpte_group_search_chk #(
    parameter int GRP_W  = 10,
    parameter int SLOTS  = 8,
    parameter int DW     = 64,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ADDR_W = GRP_W + SLOT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              done,
    input logic              hit,
    input logic [SLOT_W-1:0] hit_slot,
    input logic [DW-1:0]     hit_r
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> rd_addr[SLOT_W-1:0] == '0);

    // R2
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |->
            (rd_addr[SLOT_W-1:0] == $past(rd_addr[SLOT_W-1:0]) + SLOT_W'(1)) &&
            (rd_addr[ADDR_W-1:SLOT_W] == $past(rd_addr[ADDR_W-1:SLOT_W])));

    // R2
    no_read_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_en);

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (hit_slot == '0) && (hit_r == '0));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(hit) && $stable(hit_slot) && $stable(hit_r));
endmodule

bind hpte_group_search hpte_group_search_chk #(
    .GRP_W (GRP_W),
    .SLOTS (SLOTS),
    .DW    (DW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .done     (done),
    .hit      (hit),
    .hit_slot (hit_slot),
    .hit_r    (hit_r)
);

// File: tb/sim_hpte_group_search.sv
`timescale 1ns/1ps
module sim_hpte_group_search;
    localparam int GRP_W  = 10;
    localparam int RD_LAT = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [GRP_W-1:0] grp_idx = '0;
    logic [63:0]      tgt_v = '0;
    logic             use_sec = 1'b0;
    logic             rd_en;
    logic [GRP_W+2:0] rd_addr;
    logic [63:0]      rd_v = '0;
    logic [63:0]      rd_r = '0;
    logic             done;
    logic             hit;
    logic [2:0]       hit_slot;
    logic [63:0]      hit_r;

    always #2.5 clk = ~clk;

    hpte_group_search #(.GRP_W(GRP_W), .RD_LAT(RD_LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .grp_idx(grp_idx),
        .tgt_v(tgt_v), .use_sec(use_sec), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_v(rd_v), .rd_r(rd_r), .done(done), .hit(hit),
        .hit_slot(hit_slot), .hit_r(hit_r)
    );

    logic [63:0] mv [8];
    logic [63:0] mr [8];

    always @(posedge clk) begin
        if (rd_en) begin
            rd_v <= mv[rd_addr[2:0]];
            rd_r <= mr[rd_addr[2:0]];
        end
    end

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        hit;
        logic [2:0]  slot;
        logic [63:0] r;
        int unsigned lat;
        int unsigned t0;
        string       tag;
    } exp_t;

    exp_t             sb [$];
    logic [GRP_W-1:0] exp_grp = '0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [63:0] ent(input logic [54:0] avpn, input logic [6:0] fl);
        return {2'b00, avpn, fl};
    endfunction

    function automatic exp_t model(input logic [63:0] t, input logic s, input string tag);
        exp_t e;
        e.hit = 1'b0; e.slot = '0; e.r = '0; e.lat = 8 + RD_LAT; e.tag = tag; e.t0 = 0;
        for (int k = 7; k >= 0; k--) begin
            if ((((mv[k] ^ t) & ~64'h7F) == 64'd0) && mv[k][0] && (mv[k][1] == s)) begin
                e.hit = 1'b1; e.slot = 3'(k); e.r = mr[k]; e.lat = k + 1 + RD_LAT;
            end
        end
        return e;
    endfunction

    task automatic fire(input logic [GRP_W-1:0] g, input logic [63:0] t,
                        input logic s, input string tag);
        exp_t e;
        e = model(t, s, tag);
        e.t0 = cyc;
        sb.push_back(e);
        exp_grp = g;
        grp_idx = g; tgt_v = t; use_sec = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic search(input logic [GRP_W-1:0] g, input logic [63:0] t,
                          input logic s, input string tag);
        fire(g, t, s, tag);
        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic fill(input logic [63:0] v);
        for (int k = 0; k < 8; k++) begin
            mv[k] = v;
            mr[k] = 64'h1000 * (k + 1) + 64'h183;
        end
    endtask

    // Scoreboard monitor, read-order monitor and pulse-width monitor
    logic       prev_rd = 1'b0;
    logic [2:0] prev_slot = '0;
    logic       prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en) begin
                chk("R2", "read group", 64'(rd_addr[GRP_W+2:3]), 64'(exp_grp));
                chk("R2", "read slot", 64'(rd_addr[2:0]),
                    prev_rd ? 64'(3'(prev_slot + 3'd1)) : 64'd0);
            end
            if (done) begin
                chk("R2", "no read at done", 64'(rd_en), 64'd0);
                if (prev_done) chk("R9", "done width", 64'd2, 64'd1);
                if (sb.size() == 0) begin
                    chk("R10", "unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.tag, "hit", 64'(hit), 64'(e.hit));
                    chk(e.tag, "slot", 64'(hit_slot), 64'(e.slot));
                    chk(e.tag, "r word", hit_r, e.r);
                    chk(e.tag, "latency", 64'(cyc - e.t0 - 1), 64'(e.lat));
                end
            end
            prev_rd   = rd_en;
            prev_slot = rd_addr[2:0];
            prev_done = done;
        end
    end

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [54:0] PA = 55'h12_3456_789A;
    localparam logic [54:0] PB = 55'h0F_0F0F_0F0F;

    initial begin
        fill(ent(PB, 7'h01));
        repeat (4) @(negedge clk);
        // R1 reset values
        chk("R1", "done", 64'(done), 0);
        chk("R1", "hit", 64'(hit), 0);
        chk("R1", "rd_en", 64'(rd_en), 0);
        chk("R1", "slot", 64'(hit_slot), 0);
        chk("R1", "r", hit_r, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 exact hit in slot 3
        fill(ent(PB, 7'h01)); mv[3] = ent(PA, 7'h01);
        search(10'h2A5, ent(PA, 7'h01), 1'b0, "R7");

        // R3 low flag bits differ (large, lock, bolted, bits 6:5)
        fill(ent(PB, 7'h01)); mv[4] = ent(PA, 7'h7D);
        search(10'h011, ent(PA, 7'h00), 1'b0, "R3");

        // R3 bit 7 differs in slot 2, exact in slot 5
        fill(ent(PB, 7'h01)); mv[2] = ent(PA ^ 55'h1, 7'h01); mv[5] = ent(PA, 7'h01);
        search(10'h3FF, ent(PA, 7'h01), 1'b0, "R3");

        // R3 bit 63 differs only: miss
        fill(ent(PB, 7'h01)); mv[1] = ent(PA, 7'h01) | 64'h8000_0000_0000_0000;
        search(10'h001, ent(PA, 7'h01), 1'b0, "R3");

        // R4 invalid slot 0, valid at slot 6
        fill(ent(PB, 7'h01)); mv[0] = ent(PA, 7'h00); mv[6] = ent(PA, 7'h01);
        search(10'h100, ent(PA, 7'h01), 1'b0, "R4");

        // R5 secondary bit mismatch, then match
        fill(ent(PB, 7'h01)); mv[2] = ent(PA, 7'h03);
        search(10'h055, ent(PA, 7'h01), 1'b0, "R5");
        search(10'h055, ent(PA, 7'h01), 1'b1, "R5");

        // R6 several matches: lowest wins
        fill(ent(PB, 7'h01)); mv[1] = ent(PA, 7'h05); mv[4] = ent(PA, 7'h01);
        search(10'h0AA, ent(PA, 7'h01), 1'b0, "R6");

        // R8 miss everywhere
        fill(ent(PB, 7'h01));
        search(10'h0F0, ent(PA, 7'h01), 1'b0, "R8");

        // R7 boundary slots 0 and 7
        fill(ent(PB, 7'h01)); mv[0] = ent(PA, 7'h01);
        search(10'h007, ent(PA, 7'h01), 1'b0, "R7");
        fill(ent(PB, 7'h01)); mv[7] = ent(PA, 7'h01);
        search(10'h007, ent(PA, 7'h01), 1'b0, "R7");

        // R11 outputs held after the slot 7 hit
        repeat (5) @(negedge clk);
        chk("R11", "hit held", 64'(hit), 1);
        chk("R11", "slot held", 64'(hit_slot), 7);
        chk("R11", "r held", hit_r, mr[7]);
        chk("R9", "done low", 64'(done), 0);

        // R10 start while busy ignored
        fill(ent(PB, 7'h01)); mv[5] = ent(PA, 7'h01); mv[1] = ent(PB, 7'h01);
        fire(10'h0C3, ent(PA, 7'h01), 1'b0, "R10");
        @(negedge clk);
        grp_idx = 10'h111; tgt_v = ent(PB, 7'h01); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);

        // R10 start in the done cycle is accepted
        fill(ent(PB, 7'h01)); mv[2] = ent(PA, 7'h01);
        fire(10'h0E1, ent(PA, 7'h01), 1'b0, "R10");
        while (!done) @(negedge clk);
        fire(10'h0E1, ent(PB, 7'h01), 1'b0, "R10");
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule